// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the serial side of an SPI master. It takes one parallel word at a time and shifts a frame of 4, 8 or 16 bits out on MOSI. In the same bit periods it gathers the bits on MISO into a received word. Static configuration inputs set the clock idle level, the clock phase, the bit order, the transfer direction, the chip-select behaviour between frames and the lead time from select to the first bit. The serial clock half-period is a count of system clocks taken from a divider input.

Transmit words enter through a valid/ready push port. The producer raises `tx_valid` with `tx_data` and must hold both stable until a rising clock edge on which `tx_ready` is also high. That edge transfers the word. `tx_ready` is high only while the engine is idle, or in the final system cycle of a frame. A word that waits in that final cycle follows on directly. Received words leave on a valid-only port with no back-pressure, so the consumer must take `rx_data` in the cycle that `rx_valid` is high. In receive-only mode frames are started by pulses on `rx_start` instead of by transmit words.

Top module: `spi_frame_engine`

## Requirements
- R1: `cfg_size` sets the frame length: code 0 gives 4 bits, code 1 gives 8, code 2 gives 16, and code 3 is treated as 8. One frame keeps chip select low for the lead time plus 2×bits×H system clocks, where H is the half-period.
- R2: While `cs_n` is high, and during the lead time, `sclk` equals `cfg_cpol` (0 means idle low, 1 means idle high).
- R3: With `cfg_cpha`=0 each bit is on MOSI before the first clock edge of its bit period, and both sides sample on that first (leading) edge. With `cfg_cpha`=1 each bit is launched on the leading edge and sampled on the trailing edge. The engine samples MISO on the same edge that the slave samples MOSI.
- R4: With `cfg_lsb_first`=0 bit N-1 of the word goes out first. With 1, bit 0 goes out first. Received serial bits are placed using the same rule, so the word is right-aligned and bits N..15 of `rx_data` are zero.
- R5: When a next frame is ready at the end of a frame, `cfg_cs_gap` sets what chip select does between the two frames. Codes 0 and 3 keep `cs_n` low. Code 1 drives it high for H system clocks. Code 2 drives it high for 2H.
- R6: From `cs_n` falling to the start of the first bit period takes H system clocks when `cfg_lead_full`=0, and 2H when it is 1. This applies after a gap as well. With `cfg_cpha`=1 the first clock edge comes at that point; with `cfg_cpha`=0 it comes H later.
- R7: `cfg_xfer_mode` sets the direction. Codes 0 and 3 transmit and receive. Code 1 transmits only and never raises `rx_valid`. Code 2 receives only: MOSI stays low, `tx_ready` stays low, and each `rx_start` pulse asks for one frame.
- R8: H equals `cfg_div` with bit 0 cleared, but never less than 2. So 0 and 1 give 2, and 7 gives 6.
- R9: When a frame ends with no next frame ready, `cs_n` goes high and `sclk` returns to idle at once. `busy` stays high for exactly one more system clock and then falls. `busy` is high whenever `cs_n` is low.
- R10: Each received frame produces exactly one single-cycle `rx_valid` pulse, in the first system cycle after the frame's final half-period.
- R11: A transmit word is taken only on an edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low in the middle of a frame. Changing `tx_data` after the handshake has no effect on the frame being sent.
- R12: During reset `cs_n` is high, `busy`, `mosi` and `rx_valid` are low, and `sclk` equals `cfg_cpol`.
- R13: In receive-only mode, an `rx_start` pulse that arrives while a frame is in progress is held. It starts one further frame when the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 2 | Frame length code |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_lsb_first | input | 1 | Bit order, 1 = least significant first |
| cfg_xfer_mode | input | 2 | Direction: duplex, transmit-only, receive-only |
| cfg_cs_gap | input | 2 | Chip-select behaviour between consecutive frames |
| cfg_lead_full | input | 1 | Select-to-first-bit lead, 0 = H, 1 = 2H |
| cfg_div | input | DIV_W | Half-period in system clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken this cycle |
| tx_data | input | FRAME_W | Transmit word, right-aligned |
| rx_start | input | 1 | Frame request pulse in receive-only mode |
| rx_valid | output | 1 | Received word present (one cycle) |
| rx_data | output | FRAME_W | Received word, right-aligned |
| busy | output | 1 | Engine active |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Some rules hold on every cycle and the bound checker watches them continuously. These are: the idle clock level whenever the select is high, busy covering every low-select cycle, the one-cycle busy tail, single-cycle receive pulses, a silent MOSI and a closed transmit port in receive-only mode, and no received words in transmit-only mode. Other behaviour shows only in the bench's loopback slave scenarios. This covers the serial bit order on both lines, the sampling edge for each clock polarity and phase, the frame length for each size code, the lead and gap durations counted in system clocks, divider clamping and rounding, and the order of back-to-back and queued receive-only frames.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_BITS = 3'd2,
    ST_GAP  = 3'd3,
    ST_DONE = 3'd4
  } fe_state_t;

  typedef enum logic [1:0] {
    XM_DUPLEX  = 2'd0,
    XM_TX_ONLY = 2'd1,
    XM_RX_ONLY = 2'd2,
    XM_SPARE   = 2'd3
  } xfer_mode_e;

  // frame length in bits for a size code; the spare code falls back to 8
  function automatic int unsigned frame_len(input logic [1:0] code);
    case (code)
      2'd0:    return 4;
      2'd2:    return 16;
      default: return 8;
    endcase
  endfunction

  // half-periods of high select between frames; codes 0 and 3 keep it low
  function automatic int unsigned gap_halves(input logic [1:0] code);
    case (code)
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] half_len;
  logic [DIV_W-1:0] cnt;

  // even length, floor of two system clocks
  always_comb begin
    if (div < DIV_W'(2)) half_len = DIV_W'(2);
    else                 half_len = {div[DIV_W-1:1], 1'b0};
  end

  assign tick = run && (cnt == half_len - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_bit_index.sv
module spi_bit_index #(
  parameter int FRAME_W = 16,
  parameter int PW      = $clog2(FRAME_W),
  parameter int IDX_W   = PW + 1
) (
  input  logic [IDX_W-1:0] nbits,
  input  logic [IDX_W-1:0] ordinal,
  input  logic             lsb_first,
  output logic [PW-1:0]    pos
);
  // serial ordinal to word bit position, shared by both directions
  assign pos = lsb_first ? ordinal[PW-1:0]
                         : PW'(nbits - IDX_W'(1) - ordinal);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_fe_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_size,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_lsb_first,
  input  logic [1:0]         cfg_xfer_mode,
  input  logic [1:0]         cfg_cs_gap,
  input  logic               cfg_lead_full,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               rx_start,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_data,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               cs_n
);
  localparam int PW     = $clog2(FRAME_W);
  localparam int IDX_W  = PW + 1;
  localparam int HALF_W = IDX_W + 1;

  fe_state_t          state;
  logic [HALF_W-1:0]  half_k;
  logic [FRAME_W-1:0] tx_word, rx_acc;
  logic               rx_pend;

  logic [IDX_W-1:0]  nbits;
  logic [HALF_W-1:0] lead_h, gap_h, frame_h;
  logic [PW-1:0]     pos;
  logic              tick, run, rx_only, tx_only;
  logic              frame_end, capture, next_avail, start_idle;

  assign rx_only = (cfg_xfer_mode == XM_RX_ONLY);
  assign tx_only = (cfg_xfer_mode == XM_TX_ONLY);
  assign nbits   = IDX_W'(frame_len(cfg_size));
  assign frame_h = {1'b0, nbits} << 1;
  assign lead_h  = cfg_lead_full ? HALF_W'(2) : HALF_W'(1);
  assign gap_h   = HALF_W'(gap_halves(cfg_cs_gap));
  assign run     = (state == ST_LEAD) || (state == ST_BITS) || (state == ST_GAP);

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
  );

  spi_bit_index #(.FRAME_W(FRAME_W)) u_index (
    .nbits(nbits), .ordinal(half_k[HALF_W-1:1]),
    .lsb_first(cfg_lsb_first), .pos(pos)
  );

  assign frame_end  = (state == ST_BITS) && tick && (half_k == frame_h - HALF_W'(1));
  assign capture    = (state == ST_BITS) && tick && !half_k[0];
  assign next_avail = rx_only ? (rx_pend || rx_start) : tx_valid;
  assign start_idle = (state == ST_IDLE) && next_avail;
  assign tx_ready   = !rx_only && ((state == ST_IDLE) || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half_k   <= '0;
      tx_word  <= '0;
      rx_acc   <= '0;
      rx_pend  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start_idle) begin
          state   <= ST_LEAD;
          half_k  <= '0;
          tx_word <= rx_only ? '0 : tx_data;
          rx_acc  <= '0;
          rx_pend <= 1'b0;
        end
        ST_LEAD: if (tick) begin
          if (half_k == lead_h - HALF_W'(1)) begin
            state  <= ST_BITS;
            half_k <= '0;
          end else half_k <= half_k + HALF_W'(1);
        end
        ST_BITS: begin
          if (capture) rx_acc[pos] <= miso;
          if (frame_end) begin
            if (!tx_only) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_acc;
            end
            if (next_avail) begin
              tx_word <= rx_only ? '0 : tx_data;
              rx_acc  <= '0;
              rx_pend <= 1'b0;
              half_k  <= '0;
              state   <= (gap_h == '0) ? ST_BITS : ST_GAP;
            end else state <= ST_DONE;
          end else if (tick) half_k <= half_k + HALF_W'(1);
        end
        ST_GAP: if (tick) begin
          if (half_k == gap_h - HALF_W'(1)) begin
            state  <= ST_LEAD;
            half_k <= '0;
          end else half_k <= half_k + HALF_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
      if (rx_only && rx_start && !start_idle && !frame_end) rx_pend <= 1'b1;
    end
  end

  assign sclk  = (state == ST_BITS) ? (cfg_cpol ^ (cfg_cpha ? ~half_k[0] : half_k[0]))
                                    : cfg_cpol;
  assign mosi  = !rx_only && ((state == ST_LEAD) || (state == ST_BITS)) && tx_word[pos];
  assign cs_n  = !((state == ST_LEAD) || (state == ST_BITS));
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic [1:0] cfg_xfer_mode,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       rx_valid,
  input logic       tx_ready
);
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cfg_cpol));

  a_r9_busy_covers_select: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r9_busy_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && $past(cs_n)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_rx_only_mosi_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_xfer_mode == 2'd2) |-> !mosi);

  a_r7_rx_only_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_xfer_mode == 2'd2) |-> !tx_ready);

  a_r7_tx_only_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_xfer_mode == 2'd1) |-> !rx_valid);
endmodule

bind spi_frame_engine spi_frame_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_xfer_mode(cfg_xfer_mode),
  .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy),
  .rx_valid(rx_valid), .tx_ready(tx_ready)
);

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  cfg_size = 2'd1, cfg_xfer_mode = 2'd0, cfg_cs_gap = 2'd0;
  logic        cfg_cpol = 1'b1, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_lead_full = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic        tx_valid = 1'b0, rx_start = 1'b0, miso = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, busy, sclk, mosi, cs_n;
  logic [15:0] rx_data;

  spi_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_xfer_mode(cfg_xfer_mode),
    .cfg_cs_gap(cfg_cs_gap), .cfg_lead_full(cfg_lead_full), .cfg_div(cfg_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_start(rx_start),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // loopback slave: restarts its bit streams at each select fall
  bit s_bits[64];
  bit m_bits[64];
  int si = 0, mi = 0;

  always @(negedge cs_n) begin
    si = 0; mi = 0;
    if (!cfg_cpha) begin miso = s_bits[0]; si = 1; end
    else miso = 1'b0;
  end

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      automatic bit leading = (sclk != cfg_cpol);
      if (leading != cfg_cpha) begin
        if (mi < 64) m_bits[mi] = mosi;
        mi++;
      end else begin
        if (si < 64) miso = s_bits[si];
        si++;
      end
    end
  end

  // port monitor, sampled away from the active edge
  logic [15:0] rx_q[8];
  int rx_n = 0, lead_cnt = 0, hi_run = 0, low_run = 0, gap_last = 0, low_last = 0;
  bit edge_seen = 0, mosi_bad = 0, prev_cs = 1, post_rise = 0;
  bit busy_at_rise = 0, sclk_idle_at_rise = 0, busy_after = 1;

  always @(negedge clk) begin
    if (post_rise) begin busy_after = busy; post_rise = 0; end
    if (prev_cs && !cs_n) begin
      lead_cnt = 0; edge_seen = 0; gap_last = hi_run; low_run = 0;
    end
    if (!prev_cs && cs_n) begin
      low_last = low_run; busy_at_rise = busy;
      sclk_idle_at_rise = (sclk == cfg_cpol); post_rise = 1;
    end
    if (!cs_n) begin
      hi_run = 0; low_run++;
      if (!edge_seen) begin
        if (sclk == cfg_cpol) lead_cnt++;
        else edge_seen = 1;
      end
      if (cfg_xfer_mode == 2'd2 && mosi) mosi_bad = 1;
    end else hi_run++;
    if (rx_valid) begin
      if (rx_n < 8) rx_q[rx_n] = rx_data;
      rx_n++;
    end
    prev_cs = cs_n;
  end

  task automatic set_pattern(input logic [31:0] p);
    for (int j = 0; j < 64; j++) s_bits[j] = p[j % 32];
  endtask

  function automatic int nbits_of(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd2) ? 16 : 8;
  endfunction

  function automatic logic [15:0] exp_rx(input int n, input bit lsb, input int off);
    logic [15:0] w = '0;
    for (int j = 0; j < n; j++) w[lsb ? j : n-1-j] = s_bits[off+j];
    return w;
  endfunction

  function automatic logic [15:0] exp_serial(input logic [15:0] tx, input int n, input bit lsb);
    logic [15:0] w = '0;
    for (int j = 0; j < n; j++) w[j] = tx[lsb ? j : n-1-j];
    return w;
  endfunction

  function automatic logic [15:0] got_serial(input int n, input int off);
    logic [15:0] w = '0;
    for (int j = 0; j < n; j++) w[j] = m_bits[off+j];
    return w;
  endfunction

  task automatic push(input logic [15:0] w);
    tx_data = w; tx_valid = 1'b1;
    #1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = ~w;  // R11: changing data after the handshake must not matter
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic clear_mon();
    rx_n = 0; mosi_bad = 0;
  endtask

  // {size, cpol, cpha, lsb_first, tx word, slave pattern}
  localparam logic [36:0] VEC [13] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C},
    {2'd1, 1'b0, 1'b1, 1'b0, 16'h0081, 16'h00F0},
    {2'd1, 1'b1, 1'b0, 1'b0, 16'h005A, 16'h0011},
    {2'd1, 1'b1, 1'b1, 1'b0, 16'h00C3, 16'h0077},
    {2'd1, 1'b0, 1'b0, 1'b1, 16'h0096, 16'h00E1},
    {2'd1, 1'b1, 1'b1, 1'b1, 16'h0012, 16'h0034},
    {2'd0, 1'b0, 1'b0, 1'b0, 16'h000B, 16'h0006},
    {2'd0, 1'b1, 1'b1, 1'b1, 16'h0009, 16'h000E},
    {2'd0, 1'b0, 1'b1, 1'b1, 16'h0004, 16'h0003},
    {2'd2, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h1234},
    {2'd2, 1'b1, 1'b1, 1'b1, 16'hC0DE, 16'hA55A},
    {2'd2, 1'b0, 1'b1, 1'b0, 16'h8001, 16'h7FFE},
    {2'd2, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hF001}
  };

  bit done = 0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      summary();
    end
  end

  initial begin
    int n;
    // R12: reset state, idle level follows polarity
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && busy == 1'b0 && mosi == 1'b0 && rx_valid == 1'b0,
          "R12 reset outputs", {cs_n, busy, mosi, rx_valid}, 4'b1000);
    check(sclk == 1'b1, "R12 reset sclk", sclk, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: polarity/phase, sizes, bit order
    for (int v = 0; v < 13; v++) begin
      cfg_size = VEC[v][36:35]; cfg_cpol = VEC[v][34]; cfg_cpha = VEC[v][33];
      cfg_lsb_first = VEC[v][32]; cfg_xfer_mode = 2'd0; cfg_cs_gap = 2'd1;
      cfg_lead_full = 1'b0; cfg_div = 8'd2;
      set_pattern({16'h0, VEC[v][15:0]});
      @(negedge clk);
      clear_mon();
      push(VEC[v][31:16]);
      wait_idle();
      n = nbits_of(cfg_size);
      check(rx_n == 1, "R10 one pulse per frame", rx_n, 1);
      check(rx_q[0] == exp_rx(n, cfg_lsb_first, 0), "R4 R3 received word",
            rx_q[0], exp_rx(n, cfg_lsb_first, 0));
      check(got_serial(n, 0) == exp_serial(VEC[v][31:16], n, cfg_lsb_first),
            "R3 R4 R11 MOSI bits", got_serial(n, 0), exp_serial(VEC[v][31:16], n, cfg_lsb_first));
      check(lead_cnt == (cfg_cpha ? 2 : 4), "R6 lead to first edge", lead_cnt, cfg_cpha ? 2 : 4);
      check(low_last == 2 + 4*n, "R1 frame length", low_last, 2 + 4*n);
      check(busy_at_rise && !busy_after && sclk_idle_at_rise, "R9 tail",
            {busy_at_rise, busy_after, sclk_idle_at_rise}, 3'b101);
    end

    // R1: spare size code behaves as 8 bits
    cfg_size = 2'd3; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
    set_pattern(32'h0000_0033);
    clear_mon(); push(16'h00C5); wait_idle();
    check(low_last == 34, "R1 code 3 length", low_last, 34);
    check(rx_q[0] == exp_rx(8, 0, 0), "R1 code 3 word", rx_q[0], exp_rx(8, 0, 0));

    // R11: port closed mid-frame
    cfg_size = 2'd2; clear_mon();
    push(16'h1357);
    repeat (10) @(negedge clk);
    check(tx_ready == 1'b0 && busy == 1'b1, "R11 ready low mid-frame", tx_ready, 0);
    wait_idle();

    // R7: transmit-only gives no received word
    cfg_size = 2'd1; cfg_xfer_mode = 2'd1; clear_mon();
    push(16'h006B); wait_idle();
    check(rx_n == 0, "R7 tx-only no rx", rx_n, 0);
    check(got_serial(8, 0) == exp_serial(16'h006B, 8, 0), "R7 tx-only mosi",
          got_serial(8, 0), exp_serial(16'h006B, 8, 0));

    // R7 R13: receive-only, start pulse, queued second pulse
    cfg_xfer_mode = 2'd2; cfg_cs_gap = 2'd1; cfg_cpha = 1; tx_data = 16'hFFFF;
    set_pattern(32'h0000_00B4);
    clear_mon();
    @(negedge clk);
    check(tx_ready == 1'b0, "R7 rx-only port closed", tx_ready, 0);
    rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
    repeat (6) @(negedge clk);
    rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
    wait_idle();
    check(rx_n == 2, "R13 queued start gives two frames", rx_n, 2);
    check(rx_q[0] == exp_rx(8, 0, 0) && rx_q[1] == exp_rx(8, 0, 0), "R7 rx-only words",
          rx_q[1], exp_rx(8, 0, 0));
    check(mosi_bad == 0, "R7 rx-only mosi low", mosi_bad, 0);
    check(gap_last == 2, "R5 gap in rx-only", gap_last, 2);

    // R5: gap codes with back-to-back frames, 4-bit, H=2
    cfg_xfer_mode = 2'd0; cfg_size = 2'd0; cfg_cpha = 1; cfg_cpol = 1;
    set_pattern(32'h0000_5C3A);
    for (int g = 0; g < 4; g++) begin
      cfg_cs_gap = g[1:0];
      clear_mon();
      push(16'h0009); push(16'h0006);
      wait_idle();
      check(rx_n == 2, "R5 two frames", rx_n, 2);
      if (g == 1 || g == 2) begin
        check(gap_last == 2*g, "R5 gap width", gap_last, 2*g);
        check(rx_q[1] == exp_rx(4, 0, 0), "R5 second word after gap", rx_q[1], exp_rx(4, 0, 0));
      end else begin
        check(low_last == 34, "R5 select held low", low_last, 34);
        check(rx_q[1] == exp_rx(4, 0, 4), "R5 second word continuous", rx_q[1], exp_rx(4, 0, 4));
        check(got_serial(4, 4) == exp_serial(16'h0006, 4, 0), "R5 second mosi",
              got_serial(4, 4), exp_serial(16'h0006, 4, 0));
      end
    end

    // R6: full lead, H=4
    cfg_size = 2'd1; cfg_cs_gap = 2'd0; cfg_lead_full = 1; cfg_div = 8'd4;
    for (int p = 1; p >= 0; p--) begin
      cfg_cpha = p[0];
      clear_mon(); push(16'h0055); wait_idle();
      check(lead_cnt == (p ? 8 : 12), "R6 full lead", lead_cnt, p ? 8 : 12);
    end

    // R8: divider clamp and rounding
    cfg_lead_full = 0; cfg_cpha = 1;
    cfg_div = 8'd0; clear_mon(); push(16'h0033); wait_idle();
    check(lead_cnt == 2, "R8 div 0 clamps to 2", lead_cnt, 2);
    cfg_div = 8'd1; clear_mon(); push(16'h0033); wait_idle();
    check(lead_cnt == 2, "R8 div 1 clamps to 2", lead_cnt, 2);
    cfg_div = 8'd7; clear_mon(); push(16'h0033); wait_idle();
    check(lead_cnt == 6, "R8 div 7 rounds to 6", lead_cnt, 6);
    check(low_last == 6 + 96, "R8 frame length at H=6", low_last, 102);

    done = 1;
    summary();
  end
endmodule